// File: doc/BRIEF.md
# Lane Mask Reconvergence Stack

This block holds the active-lane mask of a 16-lane processor in which every lane runs the same instruction stream. A compare instruction leaves one predicate bit per lane. Branch instructions carry a two-bit control code that tells this block how to handle the two sides of a divergent if/else, which are issued one after the other. A code of push opens a divergent region. A code of complement switches to the other side of that region. A code of pop closes the region. Every lane steps through every instruction, but a lane only writes back its result when its bit in the active mask is set.

On push, the current mask is saved on a small hardware stack and the lanes whose predicate is clear are switched off. On complement, the active lanes are inverted within the mask saved for the enclosing region, so lanes that were already off stay off. On pop, the saved mask comes back. Regions nest up to the stack depth. A push when the stack is full and a pop when it is empty are refused, and each raises its own sticky flag. All state changes take effect at the clock edge that samples the instruction.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, `act_mask` is all ones, `depth` is 0, and `ovf` and `udf` are 0.
- R2: With `instr_vld`=1 and `br_ctrl`=2'b01 (push) while `depth` is below DEPTH, after the edge `act_mask` equals the old mask AND `pred`, the old mask is saved, and `depth` goes up by one.
- R3: With `instr_vld`=1 and `br_ctrl`=2'b10 (complement), after the edge `act_mask` equals NOT the old mask AND the reference mask, and `depth` is unchanged. The reference mask is the most recently saved mask, or all ones when `depth` is 0.
- R4: With `instr_vld`=1 and `br_ctrl`=2'b11 (pop) while `depth` is above 0, after the edge `act_mask` equals the most recently saved mask and `depth` goes down by one.
- R5: When `instr_vld`=0, whatever the code, or when `br_ctrl`=2'b00 (none), the mask and the depth keep their values.
- R6: A push while `depth` equals DEPTH (8) sets `ovf` and leaves the mask and the depth unchanged.
- R7: A pop while `depth` is 0 sets `udf` and leaves the mask and the depth unchanged.
- R8: Once set, `ovf` and `udf` stay set until reset, through any later instructions.
- R9: Saved masks come back in last-in first-out order across all DEPTH nesting levels, and `depth` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | An instruction is present this cycle |
| br_ctrl | input | 2 | Branch control: 00 none, 01 push, 10 complement, 11 pop |
| pred | input | 16 | Per-lane predicate bits from the last compare |
| act_mask | output | 16 | Active-lane mask, gates lane write-back |
| depth | output | 4 | Number of saved masks on the stack (0 to 8) |
| ovf | output | 1 | Sticky: a push was refused because the stack was full |
| udf | output | 1 | Sticky: a pop was refused because the stack was empty |

## Verification
A saved entry that is written to the wrong slot, or read back from the wrong slot, does not show at once. It shows only at the complement or pop that reads that level, and that can be many instructions later. For this reason the bench fills the stack to its full depth with masks that are all different, then unwinds it completely. Any wrong slot then gives a wrong `act_mask` at a known edge. A miscounted depth shows within one cycle on `depth`, and it also appears as a flag raised early or missing at the full and empty boundaries. The scoreboard compares the mask, the depth and both flags after every instruction.

// File: rtl/lms_pkg.sv
package lms_pkg;
   typedef enum logic [1:0] {
      BR_NONE = 2'b00,
      BR_PUSH = 2'b01,
      BR_FLIP = 2'b10,
      BR_POP  = 2'b11
   } br_op_e;
endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
   import lms_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          instr_vld,
   input  br_op_e        op,
   output logic [DW-1:0] depth,
   output logic          empty,
   output logic          do_push,
   output logic          do_flip,
   output logic          do_pop,
   output logic          ovf,
   output logic          udf
);
   logic full;
   logic push_req;
   logic pop_req;

   always_comb begin
      empty    = (depth == '0);
      full     = (depth == DW'(DEPTH));
      push_req = instr_vld && (op == BR_PUSH);
      pop_req  = instr_vld && (op == BR_POP);
      do_push  = push_req && !full;
      do_pop   = pop_req && !empty;
      do_flip  = instr_vld && (op == BR_FLIP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth <= '0;
         ovf   <= 1'b0;
         udf   <= 1'b0;
      end else begin
         if (do_push)
            depth <= depth + DW'(1);
         else if (do_pop)
            depth <= depth - DW'(1);
         if (push_req && full)
            ovf <= 1'b1;
         if (pop_req && empty)
            udf <= 1'b1;
      end
   end
endmodule

// File: rtl/lms_store.sv
module lms_store #(
   parameter int LANES = 16,
   parameter int DEPTH = 8,
   parameter int DW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LANES-1:0] wr_data,
   input  logic [DW-1:0]    depth,
   output logic [LANES-1:0] top
);
   logic [DEPTH-1:0][LANES-1:0] hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [LANES-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '1;
         else if (push && (depth == DW'(i)))
            q <= wr_data;
      end
      assign hit[i] = (depth == DW'(i + 1)) ? q : '0;
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++)
         top = top | hit[i];
   end
endmodule

// File: rtl/lms_next.sv
module lms_next #(
   parameter int LANES = 16
) (
   input  logic [LANES-1:0] cur,
   input  logic [LANES-1:0] pred,
   input  logic [LANES-1:0] ref_mask,
   input  logic             do_push,
   input  logic             do_flip,
   input  logic             do_pop,
   output logic [LANES-1:0] nxt
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign nxt[l] = do_push ? (cur[l] & pred[l])      :
                      do_flip ? (~cur[l] & ref_mask[l]) :
                      do_pop  ? ref_mask[l]             :
                                cur[l];
   end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
   import lms_pkg::*;
#(
   parameter  int LANES = 16,
   parameter  int DEPTH = 8,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_vld,
   input  logic [1:0]       br_ctrl,
   input  logic [LANES-1:0] pred,
   output logic [LANES-1:0] act_mask,
   output logic [DW-1:0]    depth,
   output logic             ovf,
   output logic             udf
);
   if (LANES < 1) begin : g_bad_lanes
      $error("lane_mask_stack: LANES must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("lane_mask_stack: DEPTH must be at least 1");
   end

   logic             empty;
   logic             do_push;
   logic             do_flip;
   logic             do_pop;
   logic [LANES-1:0] top;
   logic [LANES-1:0] ref_mask;
   logic [LANES-1:0] nxt_mask;

   lms_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .instr_vld (instr_vld),
      .op        (br_op_e'(br_ctrl)),
      .depth     (depth),
      .empty     (empty),
      .do_push   (do_push),
      .do_flip   (do_flip),
      .do_pop    (do_pop),
      .ovf       (ovf),
      .udf       (udf)
   );

   lms_store #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (do_push),
      .wr_data (act_mask),
      .depth   (depth),
      .top     (top)
   );

   assign ref_mask = empty ? '1 : top;

   lms_next #(.LANES(LANES)) u_next (
      .cur      (act_mask),
      .pred     (pred),
      .ref_mask (ref_mask),
      .do_push  (do_push),
      .do_flip  (do_flip),
      .do_pop   (do_pop),
      .nxt      (nxt_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         act_mask <= '1;
      else
         act_mask <= nxt_mask;
   end
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
   parameter  int LANES = 16,
   parameter  int DEPTH = 8,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_vld,
   input logic [1:0]       br_ctrl,
   input logic [LANES-1:0] pred,
   input logic [LANES-1:0] act_mask,
   input logic [DW-1:0]    depth,
   input logic             ovf,
   input logic             udf,
   input logic [LANES-1:0] ref_mask
);
   p_push_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && br_ctrl == 2'b01 && depth < DW'(DEPTH)) |=>
      (act_mask == ($past(act_mask) & $past(pred))) && (depth == $past(depth) + DW'(1)));

   p_flip_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && br_ctrl == 2'b10) |=>
      (act_mask == (~$past(act_mask) & $past(ref_mask))) && $stable(depth));

   p_pop_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && br_ctrl == 2'b11 && depth != '0) |=>
      (act_mask == $past(ref_mask)) && (depth == $past(depth) - DW'(1)));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_vld || br_ctrl == 2'b00) |=> $stable(act_mask) && $stable(depth));

   p_full_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && br_ctrl == 2'b01 && depth == DW'(DEPTH)) |=>
      ovf && $stable(act_mask) && $stable(depth));

   p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && br_ctrl == 2'b11 && depth == '0) |=>
      udf && $stable(act_mask) && (depth == '0));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      udf |=> udf);

   p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DW'(DEPTH));
endmodule

bind lane_mask_stack lms_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_lms_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr_vld (instr_vld),
   .br_ctrl   (br_ctrl),
   .pred      (pred),
   .act_mask  (act_mask),
   .depth     (depth),
   .ovf       (ovf),
   .udf       (udf),
   .ref_mask  (ref_mask)
);

// File: tb/lane_mask_stack_bench.sv
module lane_mask_stack_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 16;
   localparam int DEPTH      = 8;

   typedef struct {
      logic [15:0] mask;
      int          dep;
      bit          ovf;
      bit          udf;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_vld = 1'b0;
   logic [1:0]  br_ctrl = 2'b00;
   logic [15:0] pred = '0;
   logic [15:0] act_mask;
   logic [3:0]  depth;
   logic        ovf;
   logic        udf;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   logic [15:0] m_mask;
   logic [15:0] m_stk [DEPTH];
   int          m_dep;
   bit          m_ovf;
   bit          m_udf;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_lane_mask_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .instr_vld (instr_vld),
      .br_ctrl   (br_ctrl),
      .pred      (pred),
      .act_mask  (act_mask),
      .depth     (depth),
      .ovf       (ovf),
      .udf       (udf)
   );

   task automatic compare(input exp_t e);
      n_chk++;
      if (act_mask !== e.mask || depth !== 4'(e.dep) || ovf !== e.ovf || udf !== e.udf) begin
         n_fail++;
         $display("FAIL %s: actual mask=%h depth=%0d ovf=%b udf=%b expected mask=%h depth=%0d ovf=%b udf=%b",
                  e.tag, act_mask, depth, ovf, udf, e.mask, e.dep, e.ovf, e.udf);
      end
   endtask

   // monitor: one expected item per instruction edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) compare(sb_q.pop_front());
      end
   end

   task automatic issue(input logic v, input logic [1:0] c, input logic [15:0] p, input string tag);
      exp_t e;
      @(negedge clk);
      instr_vld = v;
      br_ctrl   = c;
      pred      = p;
      if (v) begin
         case (c)
            2'b01: if (m_dep == DEPTH) m_ovf = 1'b1;
                   else begin
                      m_stk[m_dep] = m_mask;
                      m_dep++;
                      m_mask = m_mask & p;
                   end
            2'b10: m_mask = ~m_mask & ((m_dep == 0) ? 16'hFFFF : m_stk[m_dep - 1]);
            2'b11: if (m_dep == 0) m_udf = 1'b1;
                   else begin
                      m_dep--;
                      m_mask = m_stk[m_dep];
                   end
            default: ;
         endcase
      end
      e.mask = m_mask; e.dep = m_dep; e.ovf = m_ovf; e.udf = m_udf; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic quiet();
      @(negedge clk);
      instr_vld = 1'b0;
      br_ctrl   = 2'b00;
      wait (sb_q.size() == 0);
   endtask

   task automatic do_reset();
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      instr_vld = 1'b0;
      repeat (2) @(negedge clk);
      rst_n  = 1'b1;
      m_mask = 16'hFFFF; m_dep = 0; m_ovf = 1'b0; m_udf = 1'b0;
      e.mask = m_mask; e.dep = 0; e.ovf = 1'b0; e.udf = 1'b0; e.tag = "R1";
      compare(e);
   endtask

   initial begin
      repeat (CLK_PERIOD * 2000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R5: strobe low with a push code, then code none with strobe high
      issue(1'b0, 2'b01, 16'h00FF, "R5");
      issue(1'b1, 2'b00, 16'h1234, "R5");
      // R3: complement at the outermost level uses all ones
      issue(1'b1, 2'b10, 16'h0000, "R3");
      issue(1'b1, 2'b10, 16'h0000, "R3");
      // nested if/else
      issue(1'b1, 2'b01, 16'h00FF, "R2");
      issue(1'b1, 2'b01, 16'h0F0F, "R2");
      issue(1'b1, 2'b10, 16'h0000, "R3");
      issue(1'b1, 2'b11, 16'h0000, "R4");
      issue(1'b1, 2'b10, 16'h0000, "R3");
      issue(1'b1, 2'b11, 16'h0000, "R9");
      issue(1'b1, 2'b11, 16'h0000, "R7");
      issue(1'b1, 2'b00, 16'h0000, "R8");
      quiet();
      do_reset();
      // fill to full depth, each level drops one more lane
      for (int i = 0; i < DEPTH; i++)
         issue(1'b1, 2'b01, ~(16'h0001 << i), "R2");
      issue(1'b1, 2'b01, 16'h0000, "R6");
      issue(1'b1, 2'b10, 16'h0000, "R3");
      issue(1'b1, 2'b00, 16'h0000, "R8");
      for (int i = 0; i < DEPTH; i++)
         issue(1'b1, 2'b11, 16'h0000, "R9");
      issue(1'b1, 2'b11, 16'h0000, "R7");
      issue(1'b1, 2'b01, 16'hAAAA, "R8");
      issue(1'b1, 2'b10, 16'h0000, "R8");
      quiet();
      do_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule